// File: doc/BRIEF.md
# Frame Playback Stream Source

This block replays fixed-length frames of 32-bit words as an AXI4-Stream sequence. A host-side writer fills an internal buffer one word at a time over a load handshake. Once the buffer holds a whole frame, the block plays that frame out in load order toward a downstream consumer. The consumer can slow or pause the output at any time with tready.

Playback does not depend on host time steps. If a frame is not fully drained when a step ends, it keeps draining during the steps that follow. While a frame is buffered or playing, the load port refuses new words, and each refused offer burst is counted as one lost frame. A live counter reports how many words of the current frame the consumer has taken. A copy of that counter is latched on every host step strobe, so the host can read a per-step status value.

Output rules for back-pressure:
- A word transfers only on a clock edge where tvalid and tready are both high.
- Once tvalid is raised, it stays high, and tdata and tlast hold their values, until that word transfers.
- tready may be low for any number of cycles.

Top module: `frame_playback_src`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous, active low), the block clears its state. After that edge: m_tvalid is 0, load_ready is 1, words_sent is 0, step_words is 0 and drop_count is 0.
- R2: While load_ready is 1, each edge with load_valid high stores load_data as the next word of the frame. The edge that accepts word FRAME_LEN-1 makes m_tvalid 1 and load_ready 0 in the following cycle.
- R3: Words leave on m_tdata in the order they were loaded, one per edge with m_tvalid and m_tready both high. While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast do not change.
- R4: m_tlast is 1 only with the final word (index FRAME_LEN-1) of a frame. In the cycle after that word transfers, m_tvalid is 0 and load_ready is 1.
- R5: words_sent rises by one after each transferred word and never exceeds FRAME_LEN. It equals FRAME_LEN after the frame completes and holds that value until the first word of the next frame is accepted. In the cycle after that acceptance it reads 0.
- R6: An edge with step high copies the value words_sent had before that edge into step_words. step_words is otherwise unchanged. The step strobe has no effect on playback.
- R7: While a frame is active (load_ready 0), offered words are discarded. The active frame's words still leave unchanged.
- R8: drop_count rises by one for each run of consecutive cycles in which load_valid is 1 and load_ready is 0. A run of any length counts once, and the counter wraps at 2^DROP_W.
- R9: Asserting reset in the middle of a frame abandons that frame. The next loaded frame plays from its first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Host offers a frame word |
| load_data | input | 32 | Frame word from host |
| load_ready | output | 1 | Buffer accepts words (no frame active) |
| step | input | 1 | Single-cycle host time-step strobe |
| m_tdata | output | 32 | Stream data |
| m_tvalid | output | 1 | Stream word valid |
| m_tlast | output | 1 | Final word of frame |
| m_tready | input | 1 | Consumer ready (back-pressure) |
| words_sent | output | $clog2(FRAME_LEN+1) | Words of current frame transferred |
| step_words | output | $clog2(FRAME_LEN+1) | words_sent latched at last step strobe |
| drop_count | output | DROP_W | Refused frame offers |

## Verification
Every result is one register stage from the stimulus that causes it. The edge that accepts the last load word makes m_tvalid high right after it. A transfer edge advances m_tdata, m_tlast and words_sent. A step edge updates step_words, and the first cycle of a refused burst updates drop_count just after its edge. The bench changes inputs one time unit after each rising edge and reads outputs at that same point. It then predicts each output from the handshakes it has counted up to the previous edge. The sweep covers every 4-bit tready stall pattern on a 4-word frame.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {
    FPS_FILL = 1'b0,
    FPS_PLAY = 1'b1
  } fps_state_e;
endpackage

// File: rtl/fps_frame_buffer.sv
// Frame storage: one register per word slot, written by index, read through a mux.
module fps_frame_buffer #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [DEPTH*WORD_W-1:0] slots_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) word_q <= wr_data;
    end
    assign slots_flat[g*WORD_W +: WORD_W] = word_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = slots_flat[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/fps_play_ctrl.sv
// Fill / play sequencer with the per-frame transferred-word counter.
module fps_play_ctrl
  import fps_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  output logic             load_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             m_tvalid,
  output logic             m_tlast,
  input  logic             m_tready,
  output logic [CNT_W-1:0] words_sent
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);

  fps_state_e state_q;

  assign load_ready = (state_q == FPS_FILL);
  assign m_tvalid   = (state_q == FPS_PLAY);
  assign m_tlast    = m_tvalid && (rd_idx == LAST_IDX);
  assign wr_en      = load_valid && load_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FPS_FILL;
      wr_idx     <= '0;
      rd_idx     <= '0;
      words_sent <= '0;
    end else begin
      case (state_q)
        FPS_FILL: begin
          if (load_valid) begin
            if (wr_idx == '0) words_sent <= '0;
            if (wr_idx == LAST_IDX) begin
              wr_idx  <= '0;
              rd_idx  <= '0;
              state_q <= FPS_PLAY;
            end else begin
              wr_idx <= wr_idx + 1'b1;
            end
          end
        end
        FPS_PLAY: begin
          if (m_tready) begin
            words_sent <= words_sent + 1'b1;
            if (rd_idx == LAST_IDX) begin
              rd_idx  <= '0;
              state_q <= FPS_FILL;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        default: state_q <= FPS_FILL;
      endcase
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(rd_idx)));

  assert_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> (!m_tvalid && load_ready && words_sent == FULL_CNT));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready) |=> (words_sent == $past(words_sent) + 1'b1));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    words_sent <= FULL_CNT);

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |=> ($stable(wr_idx)));
endmodule

// File: rtl/fps_step_sampler.sv
// Latches the live word count on each host step strobe.
module fps_step_sampler #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] words_in,
  output logic [CNT_W-1:0] step_words
);
  always_ff @(posedge clk) begin
    if (!rst_n)    step_words <= '0;
    else if (step) step_words <= words_in;
  end

  assert_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (step_words == $past(words_in)));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(step_words));
endmodule

// File: rtl/fps_drop_counter.sv
// Counts refused offer bursts: a contiguous run of refused cycles is one frame.
module fps_drop_counter #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic              load_ready,
  output logic [DROP_W-1:0] drop_count
);
  logic refused, refused_q;
  assign refused = load_valid && !load_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refused_q  <= 1'b0;
      drop_count <= '0;
    end else begin
      refused_q <= refused;
      if (refused && !refused_q) drop_count <= drop_count + 1'b1;
    end
  end

  assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !refused |=> $stable(drop_count));

  assert_drop_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refused && refused_q) |=> $stable(drop_count));
endmodule

// File: rtl/frame_playback_src.sv
module frame_playback_src #(
  parameter int FRAME_LEN = 8,
  parameter int DROP_W    = 16,
  localparam int WORD_W   = 32,
  localparam int IDX_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
  localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_data,
  output logic              load_ready,
  input  logic              step,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready,
  output logic [CNT_W-1:0]  words_sent,
  output logic [CNT_W-1:0]  step_words,
  output logic [DROP_W-1:0] drop_count
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  fps_play_ctrl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .words_sent(words_sent)
  );

  fps_frame_buffer #(.WORD_W(WORD_W), .DEPTH(FRAME_LEN), .IDX_W(IDX_W)) buf_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(load_data),
    .rd_idx(rd_idx), .rd_data(m_tdata)
  );

  fps_step_sampler #(.CNT_W(CNT_W)) step_i (
    .clk(clk), .rst_n(rst_n), .step(step), .words_in(words_sent),
    .step_words(step_words)
  );

  fps_drop_counter #(.DROP_W(DROP_W)) drop_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .drop_count(drop_count)
  );

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> ($stable(m_tdata) && $stable(m_tlast)));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_tvalid && $past(m_tvalid) && rst_n && $past(rst_n)) |-> load_ready);
endmodule

// File: tb/frame_playback_src_tb_top.sv
module frame_playback_src_tb_top;
  localparam int L = 4;
  localparam int CW = $clog2(L + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_valid = 1'b0;
  logic [31:0] load_data = '0;
  logic load_ready;
  logic step = 1'b0;
  logic [31:0] m_tdata;
  logic m_tvalid, m_tlast;
  logic m_tready = 1'b0;
  logic [CW-1:0] words_sent, step_words;
  logic [15:0] drop_count;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frame_playback_src #(.FRAME_LEN(L), .DROP_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .load_ready(load_ready), .step(step), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .m_tready(m_tready), .words_sent(words_sent),
    .step_words(step_words), .drop_count(drop_count)
  );

  function automatic logic [31:0] wexp(int p, int i);
    return 32'hC3000000 ^ (p << 12) ^ (i * 32'h00010203) ^ i;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R2: load one frame; checks ready each word and the play start after the last
  task automatic load_frame(int p, bit check_clear);
    for (int i = 0; i < L; i++) begin
      load_valid = 1'b1;
      load_data  = wexp(p, i);
      chk("R2 load_ready during fill", load_ready, 1);
      tick();
      if (i == 0 && check_clear) chk("R5 words_sent cleared", words_sent, 0);
    end
    load_valid = 1'b0;
    chk("R2 tvalid after last load", m_tvalid, 1);
    chk("R2 load_ready low when active", load_ready, 0);
  endtask

  // R3/R4/R5/R6: drain with a stall mask; step strobe on cycle 3
  task automatic drain(int p, int mask);
    int n = 0;
    int snap;
    for (int k = 0; k < 40 && n < L; k++) begin
      m_tready = (k >= 8) ? 1'b1 : mask[k % 4];
      step = (k == 3);
      snap = n;
      chk("R5 words_sent live", words_sent, n);
      chk("R3 tvalid held", m_tvalid, 1);
      chk("R3 tdata order", m_tdata, wexp(p, n));
      chk("R4 tlast position", m_tlast, (n == L - 1));
      if (m_tready) n++;
      tick();
      if (k == 3) chk("R6 step_words sample", step_words, snap);
      step = 1'b0;
    end
    m_tready = 1'b0;
    chk("R4 tvalid low after last", m_tvalid, 0);
    chk("R4 load_ready back", load_ready, 1);
    chk("R5 words_sent full", words_sent, L);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 tvalid", m_tvalid, 0);
    chk("R1 load_ready", load_ready, 1);
    chk("R1 words_sent", words_sent, 0);
    chk("R1 step_words", step_words, 0);
    chk("R1 drop_count", drop_count, 0);
    rst_n = 1'b1;
    tick();

    for (int p = 0; p < 16; p++) begin
      load_frame(p, p > 0);
      drain(p, p);
      tick();
      chk("R5 words_sent holds", words_sent, L);
    end

    // R7/R8: offers during an active, stalled frame
    load_frame(16, 1'b1);
    m_tready = 1'b0;
    load_valid = 1'b1; load_data = 32'hDEADBEEF;
    chk("R7 refuse ready", load_ready, 0);
    tick(); tick();
    chk("R8 one drop per burst", drop_count, 1);
    load_valid = 1'b0; tick();
    load_valid = 1'b1; load_data = 32'hBADF00D5; tick();
    load_valid = 1'b0; tick();
    chk("R8 two bursts", drop_count, 2);
    chk("R7 active word kept", m_tdata, wexp(16, 0));
    drain(16, 15);

    // R9: reset mid-frame
    load_frame(17, 1'b1);
    m_tready = 1'b1; tick(); m_tready = 1'b0;
    chk("R9 one word taken", words_sent, 1);
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    chk("R9 tvalid cleared", m_tvalid, 0);
    chk("R9 load_ready set", load_ready, 1);
    chk("R9 words_sent cleared", words_sent, 0);
    chk("R9 drop cleared", drop_count, 0);
    chk("R9 step_words cleared", step_words, 0);
    load_frame(18, 1'b0);
    drain(18, 5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule